// File: doc/BRIEF.md
# SD Host Transaction Sequencer

This block follows one SD/MMC host request from the moment its command is issued until the request completes. It takes interrupt-status words from the command/data engine and from the DMA engine. Each word arrives with a valid strobe. The block walks the request through a command phase, a data phase and a card-busy phase, and ends with a one-cycle done strobe and a final error code. While it works it emits one-cycle strobes that reset the data FIFO, stop the DMA engine, or tell the DMA engine to resume after a descriptor has completed.

The request attributes are latched when `start_i` is accepted. They are: response expected, response CRC checking, data present, transfer direction and the number of DMA descriptors. Status bits that the current phase does not consume are kept and merged into the next event. A status word can therefore arrive early without being lost. One event may carry the request through several phases in the same cycle. A programmable event timeout aborts a request that stops receiving events.

Top module: `sdtx_seq`

## Requirements
- R1: After reset `done_o`, `fifo_rst_o`, `dma_stop_o` and `dma_resume_o` are low and `err_o` is 0. Error codes are: 0 OK, 1 TIMEOUT, 2 BAD_CRC, 3 BAD_RESPONSE, 4 FAIL.
- R2: `start_i` is accepted only while no request is active. When accepted it starts the command phase, clears the recorded error and clears the stored event bits. `start_i` during an active request has no effect, and events presented while idle have no effect.
- R3: The command-error bits are int bit 1 (response error), bit 6 (response CRC) and bit 8 (response timeout). They resolve with this priority: timeout gives 1, but only when a response is expected. Otherwise CRC gives 2, but only when CRC checking is requested. Otherwise response error gives 3.
- R4: Command-done is int bit 2. It may arrive in the same event as a command error or in a later event. On command-done the request ends if an error is recorded or no data is present. Otherwise it enters the data phase.
- R5: A command error recorded while data is present pulses `dma_stop_o`.
- R6: In the data phase, a DMA completion event decrements the outstanding-descriptor count. A DMA completion is any of dma bit 0, bit 1 or bit 8. The block pulses `dma_resume_o` while descriptors remain, and enters the busy phase when the count reaches zero.
- R7: The data-error bits are int bit 9 (data timeout), bit 7 (data CRC), bit 10 (host timeout), bit 13 (start-bit error) and bit 15 (end-bit error). They resolve with this priority: data timeout gives 1, then data CRC gives 2, then end-bit error on a write gives 1, and anything else gives 4. Every data error pulses both `fifo_rst_o` and `dma_stop_o`.
- R8: In the data phase, a start-bit error or data-over (int bit 3) ends the request at once and skips the busy phase.
- R9: In the busy phase the block waits for data-over, evaluates the data-error bits of that event, and ends the request.
- R10: Status bits that no phase consumed are stored and ORed into the next valid event before it is processed.
- R11: A single event can move the request through command, data and busy phases to completion in one cycle.
- R12: After `timeout_i` consecutive clock edges with no valid event during a request, the request ends with code 1 and pulses `dma_stop_o`. Every valid event restarts the count, and a value of 0 disables the timeout.
- R13: All strobes appear in the cycle after the clock edge that sampled their cause. `done_o` lasts one cycle, and `err_o` changes only together with `done_o` and holds between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a request (command already issued) |
| rsp_exp_i | input | 1 | A response is expected |
| crc_chk_i | input | 1 | Response CRC is checked |
| has_data_i | input | 1 | A data phase follows the command |
| is_read_i | input | 1 | Data direction is card to host |
| desc_cnt_i | input | DESC_W | Number of DMA descriptors of the transfer |
| timeout_i | input | TO_W | Event timeout in cycles, 0 disables |
| evt_valid_i | input | 1 | Status words are valid this cycle |
| int_sts_i | input | 32 | Command/data engine status word |
| dma_sts_i | input | 32 | DMA engine status word |
| done_o | output | 1 | Request finished, one cycle |
| err_o | output | 3 | Final error code of the last request |
| fifo_rst_o | output | 1 | Data FIFO reset strobe |
| dma_stop_o | output | 1 | DMA stop strobe |
| dma_resume_o | output | 1 | DMA resume strobe |

## Verification
The properties assume that the surrounding engines behave. A request with data present has a descriptor count of at least one. No DMA completion arrives once the count has reached zero. At most one status word pair is presented per cycle. Every stimulus row obeys these rules. Some rows deliver bits early, before the phase that consumes them, to exercise the stored-bit merge. Others pack a whole request into one event. The directed tests place `start_i` and idle-time events deliberately, to show that both are ignored outside their window.

// File: rtl/sdtx_pkg.sv
package sdtx_pkg;
  localparam int EVT_W = 32;

  // int status bit positions
  localparam int B_RSP_ERR   = 1;
  localparam int B_CMD_DONE  = 2;
  localparam int B_DATA_OVER = 3;
  localparam int B_RSP_CRC   = 6;
  localparam int B_DAT_CRC   = 7;
  localparam int B_RSP_TO    = 8;
  localparam int B_DAT_TO    = 9;
  localparam int B_HOST_TO   = 10;
  localparam int B_START_ERR = 13;
  localparam int B_END_ERR   = 15;
  // dma status bit positions
  localparam int B_DMA_TX    = 0;
  localparam int B_DMA_RX    = 1;
  localparam int B_DMA_SUM   = 8;

  localparam logic [EVT_W-1:0] CMD_ERR_M =
      (EVT_W'(1) << B_RSP_ERR) | (EVT_W'(1) << B_RSP_CRC) | (EVT_W'(1) << B_RSP_TO);
  localparam logic [EVT_W-1:0] DAT_ERR_M =
      (EVT_W'(1) << B_DAT_TO) | (EVT_W'(1) << B_DAT_CRC) | (EVT_W'(1) << B_HOST_TO) |
      (EVT_W'(1) << B_START_ERR) | (EVT_W'(1) << B_END_ERR);
  localparam logic [EVT_W-1:0] DMA_DONE_M =
      (EVT_W'(1) << B_DMA_TX) | (EVT_W'(1) << B_DMA_RX) | (EVT_W'(1) << B_DMA_SUM);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_BUSY = 2'd3
  } seq_st_e;

  typedef enum logic [2:0] {
    E_OK      = 3'd0,
    E_TIMEOUT = 3'd1,
    E_CRC     = 3'd2,
    E_RESP    = 3'd3,
    E_FAIL    = 3'd4
  } sd_err_e;

  typedef struct packed {
    logic rto;
    logic rcrc;
    logic rerr;
    logic dto;
    logic dcrc;
    logic hto;
    logic sbe;
    logic ebe;
  } err_flags_t;
endpackage

// File: rtl/sdtx_err_class.sv
module sdtx_err_class
  import sdtx_pkg::*;
(
  input  err_flags_t flg_i,
  input  logic       rsp_exp_i,
  input  logic       crc_chk_i,
  input  logic       is_read_i,
  output sd_err_e    cmd_code_o,
  output sd_err_e    dat_code_o
);
  always_comb begin
    if (flg_i.rto && rsp_exp_i)      cmd_code_o = E_TIMEOUT;
    else if (flg_i.rcrc && crc_chk_i) cmd_code_o = E_CRC;
    else if (flg_i.rerr)             cmd_code_o = E_RESP;
    else                             cmd_code_o = E_OK;
  end

  always_comb begin
    if (flg_i.dto)                         dat_code_o = E_TIMEOUT;
    else if (flg_i.dcrc)                   dat_code_o = E_CRC;
    else if (flg_i.ebe && !is_read_i)      dat_code_o = E_TIMEOUT;
    else if (flg_i.hto || flg_i.sbe || flg_i.ebe) dat_code_o = E_FAIL;
    else                                   dat_code_o = E_OK;
  end
endmodule

// File: rtl/sdtx_evt_merge.sv
module sdtx_evt_merge #(
  parameter int W     = 32,
  parameter int WORDS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    ld_i,
  input  logic [WORDS-1:0][W-1:0] evt_i,
  input  logic [WORDS-1:0][W-1:0] left_i,
  output logic [WORDS-1:0][W-1:0] mrg_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [W-1:0] pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pend_q <= '0;
      else if (clr_i) pend_q <= '0;
      else if (ld_i)  pend_q <= left_i[g];
    end
    assign mrg_o[g] = evt_i[g] | pend_q;
  end
endmodule

// File: rtl/sdtx_wdog.sv
module sdtx_wdog #(
  parameter int TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            kick_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expire_o
);
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || kick_i)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + TO_W'(1);
  end

  assign expire_o = run_i && !kick_i && (limit_i != '0) && (cnt_q == limit_i - TO_W'(1));
endmodule

// File: rtl/sdtx_seq.sv
module sdtx_seq
  import sdtx_pkg::*;
#(
  parameter int DESC_W = 8,
  parameter int TO_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rsp_exp_i,
  input  logic              crc_chk_i,
  input  logic              has_data_i,
  input  logic              is_read_i,
  input  logic [DESC_W-1:0] desc_cnt_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic              evt_valid_i,
  input  logic [31:0]       int_sts_i,
  input  logic [31:0]       dma_sts_i,
  output logic              done_o,
  output logic [2:0]        err_o,
  output logic              fifo_rst_o,
  output logic              dma_stop_o,
  output logic              dma_resume_o
);
  localparam int NWORD = 2;
  localparam int IW    = 0;
  localparam int DW    = 1;

  seq_st_e           state_q, nxt_st;
  sd_err_e           err_q, nxt_err, err_out_q, cmd_code, dat_code;
  logic [DESC_W-1:0] cnt_q, nxt_cnt;
  logic              rsp_q, crc_q, dat_q, rd_q;
  logic              done_q, fifo_q, stop_q, res_q;
  logic              fifo_c, stop_c, res_c;
  logic              active, go, start_ok, wd_expire, finish;
  logic [NWORD-1:0][EVT_W-1:0] evt_in, evt_left, evt_mrg;
  logic [EVT_W-1:0]  m_int, m_dma, e_int, e_dma;
  err_flags_t        flg;

  assign active   = (state_q != ST_IDLE);
  assign go       = active && evt_valid_i;
  assign start_ok = start_i && !active;

  assign evt_in[IW]   = int_sts_i;
  assign evt_in[DW]   = dma_sts_i;
  assign evt_left[IW] = e_int;
  assign evt_left[DW] = e_dma;
  assign m_int        = evt_mrg[IW];
  assign m_dma        = evt_mrg[DW];

  sdtx_evt_merge #(.W(EVT_W), .WORDS(NWORD)) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .ld_i   (go),
    .evt_i  (evt_in),
    .left_i (evt_left),
    .mrg_o  (evt_mrg)
  );

  assign flg.rto  = m_int[B_RSP_TO];
  assign flg.rcrc = m_int[B_RSP_CRC];
  assign flg.rerr = m_int[B_RSP_ERR];
  assign flg.dto  = m_int[B_DAT_TO];
  assign flg.dcrc = m_int[B_DAT_CRC];
  assign flg.hto  = m_int[B_HOST_TO];
  assign flg.sbe  = m_int[B_START_ERR];
  assign flg.ebe  = m_int[B_END_ERR];

  sdtx_err_class u_class (
    .flg_i      (flg),
    .rsp_exp_i  (rsp_q),
    .crc_chk_i  (crc_q),
    .is_read_i  (rd_q),
    .cmd_code_o (cmd_code),
    .dat_code_o (dat_code)
  );

  sdtx_wdog #(.TO_W(TO_W)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (active),
    .kick_i   (evt_valid_i),
    .limit_i  (timeout_i),
    .expire_o (wd_expire)
  );

  // phases evaluated in order so one event can chain through all of them
  always_comb begin
    nxt_st  = state_q;
    nxt_err = err_q;
    nxt_cnt = cnt_q;
    e_int   = m_int;
    e_dma   = m_dma;
    fifo_c  = 1'b0;
    stop_c  = 1'b0;
    res_c   = 1'b0;
    if (go) begin
      if (nxt_st == ST_CMD) begin
        if (cmd_code != E_OK) begin
          nxt_err = cmd_code;
          stop_c  = dat_q;
        end
        e_int = e_int & ~CMD_ERR_M;
        if (m_int[B_CMD_DONE]) begin
          e_int[B_CMD_DONE] = 1'b0;
          if (nxt_err != E_OK || !dat_q) nxt_st = ST_IDLE;
          else                           nxt_st = ST_DATA;
        end
      end
      if (nxt_st == ST_DATA) begin
        if ((e_int & DAT_ERR_M) != '0) begin
          e_int   = e_int & ~DAT_ERR_M;
          nxt_err = dat_code;
          fifo_c  = 1'b1;
          stop_c  = 1'b1;
        end
        if ((e_dma & DMA_DONE_M) != '0) begin
          e_dma   = e_dma & ~DMA_DONE_M;
          nxt_cnt = cnt_q - DESC_W'(1);
          if (nxt_cnt != '0) res_c = 1'b1;
          else               nxt_st = ST_BUSY;
        end
        if (m_int[B_START_ERR] || m_int[B_DATA_OVER]) nxt_st = ST_IDLE;
      end
      if (nxt_st == ST_BUSY) begin
        if (e_int[B_DATA_OVER]) begin
          e_int[B_DATA_OVER] = 1'b0;
          if (dat_code != E_OK) begin
            nxt_err = dat_code;
            fifo_c  = 1'b1;
            stop_c  = 1'b1;
          end
          nxt_st = ST_IDLE;
        end
      end
    end
    if (wd_expire) begin
      nxt_st  = ST_IDLE;
      nxt_err = E_TIMEOUT;
      stop_c  = 1'b1;
    end
  end

  assign finish = active && (nxt_st == ST_IDLE) && (go || wd_expire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      err_q     <= E_OK;
      err_out_q <= E_OK;
      cnt_q     <= '0;
      rsp_q     <= 1'b0;
      crc_q     <= 1'b0;
      dat_q     <= 1'b0;
      rd_q      <= 1'b0;
      done_q    <= 1'b0;
      fifo_q    <= 1'b0;
      stop_q    <= 1'b0;
      res_q     <= 1'b0;
    end else begin
      done_q <= finish;
      fifo_q <= fifo_c;
      stop_q <= stop_c;
      res_q  <= res_c;
      if (finish) err_out_q <= nxt_err;
      if (start_ok) begin
        state_q <= ST_CMD;
        err_q   <= E_OK;
        cnt_q   <= desc_cnt_i;
        rsp_q   <= rsp_exp_i;
        crc_q   <= crc_chk_i;
        dat_q   <= has_data_i;
        rd_q    <= is_read_i;
      end else if (go || wd_expire) begin
        state_q <= nxt_st;
        err_q   <= nxt_err;
        cnt_q   <= nxt_cnt;
      end
    end
  end

  assign done_o       = done_q;
  assign err_o        = err_out_q;
  assign fifo_rst_o   = fifo_q;
  assign dma_stop_o   = stop_q;
  assign dma_resume_o = res_q;
endmodule

// File: rtl/sdtx_seq_chk.sv
module sdtx_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_valid_i,
  input logic       done_o,
  input logic [2:0] err_o,
  input logic       fifo_rst_o,
  input logic       dma_stop_o,
  input logic       dma_resume_o,
  input logic       active_i
);
  a_r13_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r13_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(err_o));

  a_r7_fifo_with_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_o |-> dma_stop_o);

  a_r3_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_o <= 3'd4));

  a_r2_done_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(active_i));

  a_r6_resume_after_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_resume_o |-> $past(evt_valid_i));
endmodule

bind sdtx_seq sdtx_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_valid_i  (evt_valid_i),
  .done_o       (done_o),
  .err_o        (err_o),
  .fifo_rst_o   (fifo_rst_o),
  .dma_stop_o   (dma_stop_o),
  .dma_resume_o (dma_resume_o),
  .active_i     (active)
);

// File: tb/sim_sdtx_seq.sv
`timescale 1ns/1ps
module sim_sdtx_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, rsp = 1'b0, crc = 1'b0, dat = 1'b0, rd = 1'b0;
  logic [7:0]  nd = '0;
  logic [15:0] tmo = '0;
  logic        ev = 1'b0;
  logic [31:0] iw = '0, dw = '0;
  logic        done, fifo_rst, stop, resume;
  logic [2:0]  err;

  int n_chk = 0, n_bad = 0;
  int done_n, fifo_n, stop_n, res_n, done_at, cur;

  always #2 clk = ~clk;

  sdtx_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rsp_exp_i(rsp), .crc_chk_i(crc),
    .has_data_i(dat), .is_read_i(rd), .desc_cnt_i(nd), .timeout_i(tmo),
    .evt_valid_i(ev), .int_sts_i(iw), .dma_sts_i(dw), .done_o(done), .err_o(err),
    .fifo_rst_o(fifo_rst), .dma_stop_o(stop), .dma_resume_o(resume)
  );

  typedef struct packed {
    logic rsp, crc, dat, rd;
    logic [7:0] nd;
    logic [0:3] v;
    logic [0:3][31:0] iw;
    logic [0:3][31:0] dw;
    logic [2:0] err;
    logic [3:0] at;
    logic [1:0] f, s, r;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [0:NV-1] = '{
    '{1,1,0,0, 8'd0, 4'b1000, '{32'h4,0,0,0},          '{0,0,0,0},         3'd0, 4'd0, 2'd0,2'd0,2'd0},
    '{1,1,1,1, 8'd1, 4'b1000, '{32'h104,0,0,0},        '{0,0,0,0},         3'd1, 4'd0, 2'd0,2'd1,2'd0},
    '{1,1,0,0, 8'd0, 4'b1100, '{32'h40,32'h4,0,0},     '{0,0,0,0},         3'd2, 4'd1, 2'd0,2'd0,2'd0},
    '{1,0,0,0, 8'd0, 4'b1000, '{32'h44,0,0,0},         '{0,0,0,0},         3'd0, 4'd0, 2'd0,2'd0,2'd0},
    '{1,1,0,0, 8'd0, 4'b1000, '{32'h146,0,0,0},        '{0,0,0,0},         3'd1, 4'd0, 2'd0,2'd0,2'd0},
    '{1,1,0,0, 8'd0, 4'b1000, '{32'h46,0,0,0},         '{0,0,0,0},         3'd2, 4'd0, 2'd0,2'd0,2'd0},
    '{1,1,0,0, 8'd0, 4'b1000, '{32'h6,0,0,0},          '{0,0,0,0},         3'd3, 4'd0, 2'd0,2'd0,2'd0},
    '{0,0,0,0, 8'd0, 4'b1000, '{32'h104,0,0,0},        '{0,0,0,0},         3'd0, 4'd0, 2'd0,2'd0,2'd0},
    '{1,1,1,0, 8'd2, 4'b1111, '{32'h4,0,0,32'h8},      '{0,32'h1,32'h1,0}, 3'd0, 4'd3, 2'd0,2'd0,2'd1},
    '{1,1,1,1, 8'd1, 4'b1000, '{32'hC,0,0,0},          '{32'h2,0,0,0},     3'd0, 4'd0, 2'd0,2'd0,2'd0},
    '{1,1,1,0, 8'd2, 4'b1100, '{32'h4,32'h2000,0,0},   '{0,0,0,0},         3'd4, 4'd1, 2'd1,2'd1,2'd0},
    '{1,1,1,0, 8'd1, 4'b1110, '{32'h4,0,32'h8008,0},   '{0,32'h100,0,0},   3'd1, 4'd2, 2'd1,2'd1,2'd0},
    '{1,1,1,1, 8'd1, 4'b1110, '{32'h4,0,32'h8008,0},   '{0,32'h100,0,0},   3'd4, 4'd2, 2'd1,2'd1,2'd0},
    '{1,1,1,1, 8'd1, 4'b1110, '{32'h4,0,32'h288,0},    '{0,32'h100,0,0},   3'd1, 4'd2, 2'd1,2'd1,2'd0},
    '{1,1,1,1, 8'd1, 4'b1110, '{32'h4,0,32'h488,0},    '{0,32'h100,0,0},   3'd2, 4'd2, 2'd1,2'd1,2'd0},
    '{1,1,1,1, 8'd1, 4'b1110, '{32'h4,0,32'h408,0},    '{0,32'h100,0,0},   3'd4, 4'd2, 2'd1,2'd1,2'd0},
    '{1,1,1,0, 8'd1, 4'b1100, '{32'h8,32'h4,0,0},      '{0,32'h1,0,0},     3'd0, 4'd1, 2'd0,2'd0,2'd0},
    '{1,1,1,1, 8'd1, 4'b1110, '{0,32'h4,32'h8,0},      '{32'h2,0,0,0},     3'd0, 4'd2, 2'd0,2'd0,2'd0},
    '{1,1,1,1, 8'd1, 4'b1111, '{32'h200,32'h4,0,32'h8},'{0,0,32'h1,0},     3'd1, 4'd3, 2'd1,2'd1,2'd0},
    '{1,1,1,0, 8'd1, 4'b1100, '{32'h40,32'h4,0,0},     '{0,0,0,0},         3'd2, 4'd1, 2'd0,2'd1,2'd0}
  };

  function automatic string row_tag(int n);
    case (n)
      0, 2:               return "R4";
      1, 19:              return "R5";
      3, 4, 5, 6, 7:      return "R3";
      8:                  return "R6";
      9:                  return "R11";
      10:                 return "R8";
      11, 12, 13, 14:     return "R7";
      15:                 return "R9";
      default:            return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_tally();
    done_n = 0; fifo_n = 0; stop_n = 0; res_n = 0; done_at = -1;
  endtask

  task automatic tally();
    if (done) begin done_n++; done_at = cur; end
    if (fifo_rst) fifo_n++;
    if (stop) stop_n++;
    if (resume) res_n++;
  endtask

  task automatic step(input logic v, input logic [31:0] i_w, input logic [31:0] d_w);
    @(negedge clk);
    start = 1'b0; ev = v; iw = i_w; dw = d_w;
    @(posedge clk); #1;
    tally();
  endtask

  task automatic begin_req(input logic a_rsp, a_crc, a_dat, a_rd, input logic [7:0] a_nd,
                           input logic [15:0] a_tmo);
    @(negedge clk);
    start = 1'b1; rsp = a_rsp; crc = a_crc; dat = a_dat; rd = a_rd; nd = a_nd; tmo = a_tmo;
    ev = 1'b0; iw = '0; dw = '0;
    @(posedge clk); #1;
    clr_tally();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL bench watchdog (all R) act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: reset state
    check(done == 0 && fifo_rst == 0 && stop == 0 && resume == 0, "R1 strobes", int'(done|fifo_rst|stop|resume), 0);
    check(err == 3'd0, "R1 err", err, 0);

    // vector walk
    for (int n = 0; n < NV; n++) begin
      begin_req(VT[n].rsp, VT[n].crc, VT[n].dat, VT[n].rd, VT[n].nd, 16'd0);
      for (int k = 0; k < 4; k++) begin
        cur = k;
        step(VT[n].v[k], VT[n].iw[k], VT[n].dw[k]);
      end
      cur = 9;
      step(1'b0, '0, '0);
      step(1'b0, '0, '0);
      check(done_n == 1,            {row_tag(n), " done count"}, done_n, 1);
      check(done_at == int'(VT[n].at), {row_tag(n), " done step"}, done_at, VT[n].at);
      check(err == VT[n].err,       {row_tag(n), " err code"}, err, VT[n].err);
      check(fifo_n == int'(VT[n].f), {row_tag(n), " fifo strobes"}, fifo_n, VT[n].f);
      check(stop_n == int'(VT[n].s), {row_tag(n), " stop strobes"}, stop_n, VT[n].s);
      check(res_n == int'(VT[n].r),  {row_tag(n), " resume strobes"}, res_n, VT[n].r);
    end

    // R2: events while idle ignored, nothing carried into next request
    clr_tally(); cur = 0;
    step(1'b1, 32'h146, 32'h103);
    step(1'b1, 32'h2208, 32'h1);
    check(done_n + fifo_n + stop_n + res_n == 0, "R2 idle events", done_n + fifo_n + stop_n + res_n, 0);
    begin_req(1, 1, 0, 0, 8'd0, 16'd0);
    step(1'b1, 32'h4, 32'h0);
    check(done_n == 1 && err == 3'd0, "R2 no idle carry", err, 0);

    // R2: start during active request ignored
    begin_req(1, 1, 1, 1, 8'd1, 16'd0);
    @(negedge clk);
    start = 1'b1; dat = 1'b0; ev = 1'b1; iw = 32'h4; dw = '0;
    @(posedge clk); #1; tally();
    check(done_n == 0, "R2 restart ignored", done_n, 0);
    step(1'b1, 32'h8, 32'h2);
    check(done_n == 1 && err == 3'd0, "R2 original attrs kept", done_n, 1);

    // R12: timeout with no events
    begin_req(1, 1, 1, 0, 8'd2, 16'd5);
    for (int k = 1; k <= 5; k++) begin
      cur = k;
      step(1'b0, '0, '0);
      if (k == 4) check(done_n == 0, "R12 not before limit", done_n, 0);
    end
    check(done_at == 5, "R12 timeout edge", done_at, 5);
    check(err == 3'd1 && stop_n == 1, "R12 timeout code", err, 1);
    // R13: err holds, done one cycle
    cur = 9;
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);
    check(done_n == 1 && err == 3'd1, "R13 hold after done", done_n, 1);

    // R12: an event restarts the timeout count
    begin_req(1, 1, 1, 0, 8'd2, 16'd5);
    for (int k = 1; k <= 7; k++) begin
      cur = k;
      step(k == 2, (k == 2) ? 32'h1 : 32'h0, '0);
    end
    check(done_at == 7, "R12 timeout restarted", done_at, 7);

    // R12: zero disables the timeout
    begin_req(1, 1, 0, 0, 8'd0, 16'd0);
    for (int k = 1; k <= 20; k++) begin cur = k; step(1'b0, '0, '0); end
    check(done_n == 0, "R12 disabled", done_n, 0);
    cur = 21;
    step(1'b1, 32'h4, 32'h0);
    check(done_at == 21 && err == 3'd0, "R12 completes later", done_at, 21);

    summary();
    $finish;
  end
endmodule